// File: doc/BRIEF.md
# Serial Binary-to-Decimal Converter

The block turns an unsigned binary word into packed decimal digits, four bits per digit. It works one bit per clock, most significant bit first. A single-cycle start request captures the input word and clears the digit chain. Each following clock moves one captured bit into the least significant digit cell.

Every cell doubles its digit and adds the bit it receives. If the result is ten or more, the cell keeps the result minus ten and passes a one to the next more significant cell. That carry depends only on the cell's own registered digit, so no signal ripples across more than one digit in a cycle. After the last bit, the digits are copied into an output register and a one-cycle done pulse marks them valid.

Input width and digit count are parameters. The default converts 16 bits into 5 digits.

Top module: `bin2dec_serial`

## Requirements
- R1: While rst_n is low at a clock edge, bcd_out becomes all zeros and done becomes 0.
- R2: In idle, a high start samples bin_in at that edge. Later changes on bin_in do not affect the running conversion.
- R3: done is high for exactly one cycle. It rises on the clock edge that comes IN_W+1 edges after the edge that accepted start.
- R4: When the captured value is below 10^NUM_DIG, digit k of its decimal form appears on bcd_out[4k+3:4k], with digit 0 the units.
- R5: When the captured value is 10^NUM_DIG or more, bcd_out carries the value modulo 10^NUM_DIG. The carry out of the top digit is discarded.
- R6: A start raised while a conversion is running is ignored, including in the final cycle before done. The running result and its timing are unchanged, and no extra done pulse follows.
- R7: Between done pulses, bcd_out holds its value.
- R8: Every digit register stays in the range 0 to 9. A digit of 5 or more sends a carry of one into the next cell on the shift that doubles it.
- R9: An accepted start clears all digit cells, so a conversion's result does not depend on the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, sampled while idle |
| bin_in | input | IN_W | Unsigned binary value to convert |
| bcd_out | output | 4*NUM_DIG | Registered packed decimal result, digit 0 in the low nibble |
| done | output | 1 | One-cycle pulse that marks bcd_out as newly valid |

## Verification
The assertions assume that start is only meaningful at clock edges and that reset is applied at time zero. They take the input value as arbitrary and do not depend on it. The bench keeps to these assumptions: it drives every input on the falling edge, holds reset low through the first edges, and samples outputs only on falling edges. It sweeps every value of an 8-bit, 3-digit instance and an 8-bit, 2-digit instance (the second one overflows), and runs directed values on the default instance. During some conversions it raises start in mid-shift and in the final cycle to exercise the ignore rule.

// File: rtl/bcd_conv_pkg.sv
// Shared definitions for the serial binary-to-decimal converter.
// Assumes nothing beyond IEEE 1800-2017.
package bcd_conv_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FIN   = 2'd2
    } conv_state_e;
endpackage

// File: rtl/bcd_digit_cell.sv
// One decimal digit of the shift chain. On shift_en it doubles its digit
// and adds shift_in, subtracting ten when the sum reaches ten.
// Assumes the digit stays in 0..9, so the doubled sum never exceeds 19.
module bcd_digit_cell
    import bcd_conv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic             carry_out,
    output logic [NIB_W-1:0] digit
);
    logic [NIB_W-1:0] digit_q;
    logic [NIB_W:0]   dbl;
    logic [NIB_W-1:0] digit_nxt;

    // Form the doubled value and its corrected digit.
    always_comb begin
        dbl = {digit_q, shift_in};
        if (dbl >= 5'd10) begin
            digit_nxt = 4'(dbl - 5'd10);
        end else begin
            digit_nxt = dbl[NIB_W-1:0];
        end
    end

    // The carry depends only on the registered digit, never on shift_in.
    assign carry_out = (digit_q >= 4'd5);

    // Digit register: reset, clear on start, update on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
        end else if (clr) begin
            digit_q <= '0;
        end else if (shift_en) begin
            digit_q <= digit_nxt;
        end
    end

    assign digit = digit_q;

    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= 4'd9);

    // R8
    carry_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr && carry_out) |=> (digit_q == 4'(2*$past(digit_q) + {3'd0, $past(shift_in)} - 10)));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (digit_q == '0));
endmodule

// File: rtl/bcd_seq_ctrl.sv
// Sequencer for the converter. It captures the input on an accepted start,
// feeds its bits MSB first for IN_W cycles, then spends one cycle
// finishing, during which the top level captures the result.
// Assumes IN_W >= 1. A start outside the idle state is dropped.
module bcd_seq_ctrl
    import bcd_conv_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IN_W-1:0] bin_in,
    output logic            clr,
    output logic            shift_en,
    output logic            ser_bit,
    output logic            capture,
    output logic            done
);
    localparam int CNT_W = (IN_W > 1) ? $clog2(IN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(IN_W - 1);

    conv_state_e     state_q;
    logic [IN_W-1:0] sreg_q;
    logic [CNT_W-1:0] cnt_q;
    logic            done_q;

    // Decode the per-cycle strobes from the state.
    always_comb begin
        clr      = (state_q == ST_IDLE) && start;
        shift_en = (state_q == ST_SHIFT);
        capture  = (state_q == ST_FIN);
        ser_bit  = sreg_q[IN_W-1];
    end

    // State, input shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sreg_q  <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sreg_q  <= bin_in;
                        cnt_q   <= '0;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    sreg_q <= sreg_q << 1;
                    cnt_q  <= cnt_q + 1'b1;
                    if (cnt_q == LAST_CNT) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Done pulse, registered alongside the result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= capture;
        end
    end

    assign done = done_q;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (state_q == ST_SHIFT && sreg_q == $past(bin_in)));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && start && cnt_q != LAST_CNT) |=> (state_q == ST_SHIFT && cnt_q == $past(cnt_q) + 1'b1));

    // R6
    fin_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |=> (state_q == ST_IDLE));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (cnt_q <= LAST_CNT));
endmodule

// File: rtl/bin2dec_serial.sv
// Top level of the serial binary-to-decimal converter. It chains NUM_DIG
// digit cells behind the sequencer and registers the result on the
// finishing cycle. Values of 10^NUM_DIG or more wrap modulo 10^NUM_DIG.
// Assumes a synchronous active-low reset at power-up.
module bin2dec_serial
    import bcd_conv_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int NUM_DIG = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IN_W-1:0]          bin_in,
    output logic [NIB_W*NUM_DIG-1:0] bcd_out,
    output logic                     done
);
    localparam int OUT_W = NIB_W * NUM_DIG;

    logic               clr;
    logic               shift_en;
    logic               ser_bit;
    logic               capture;
    logic [NUM_DIG-1:0] cell_in;
    logic [NUM_DIG-1:0] cell_carry;
    logic [OUT_W-1:0]   digits;
    logic [OUT_W-1:0]   bcd_q;

    bcd_seq_ctrl #(.IN_W(IN_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bin_in   (bin_in),
        .clr      (clr),
        .shift_en (shift_en),
        .ser_bit  (ser_bit),
        .capture  (capture),
        .done     (done)
    );

    // The serial bit feeds digit 0; each carry feeds the next digit up.
    assign cell_in[0] = ser_bit;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        if (g > 0) begin : g_link
            assign cell_in[g] = cell_carry[g-1];
        end
        bcd_digit_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .shift_en  (shift_en),
            .shift_in  (cell_in[g]),
            .carry_out (cell_carry[g]),
            .digit     (digits[NIB_W*g +: NIB_W])
        );
    end

    // Result register, loaded once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_q <= '0;
        end else if (capture) begin
            bcd_q <= digits;
        end
    end

    assign bcd_out = bcd_q;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(bcd_q));

    // R4
    valid_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bcd_q == $past(digits)));

    // R5
    top_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && cell_carry[NUM_DIG-1]) |=> (digits[OUT_W-1 -: NIB_W] <= 4'd9));
endmodule

// File: tb/test_bin2dec_serial.sv
`timescale 1ns/1ps
module test_bin2dec_serial;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    // Instance 0: default 16 bits, 5 digits
    logic        st0 = 1'b0;
    logic [15:0] bin0 = '0;
    logic [19:0] out0;
    logic        dn0;
    // Instance 1: 8 bits, 3 digits
    logic        st1 = 1'b0;
    logic [7:0]  bin1 = '0;
    logic [11:0] out1;
    logic        dn1;
    // Instance 2: 8 bits, 2 digits (overflows)
    logic        st2 = 1'b0;
    logic [7:0]  bin2 = '0;
    logic [7:0]  out2;
    logic        dn2;

    bin2dec_serial i_bin2dec_serial (
        .clk(clk), .rst_n(rst_n), .start(st0), .bin_in(bin0), .bcd_out(out0), .done(dn0));
    bin2dec_serial #(.IN_W(8), .NUM_DIG(3)) i_bin2dec_serial_s3 (
        .clk(clk), .rst_n(rst_n), .start(st1), .bin_in(bin1), .bcd_out(out1), .done(dn1));
    bin2dec_serial #(.IN_W(8), .NUM_DIG(2)) i_bin2dec_serial_s2 (
        .clk(clk), .rst_n(rst_n), .start(st2), .bin_in(bin2), .bcd_out(out2), .done(dn2));

    function automatic logic [31:0] exp_bcd(input int val, input int nd);
        logic [31:0] r = '0;
        int v = val;
        for (int i = 0; i < nd; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic get_done(input int sel);
        return (sel == 0) ? dn0 : (sel == 1) ? dn1 : dn2;
    endfunction

    function automatic logic [31:0] get_out(input int sel);
        return (sel == 0) ? {12'd0, out0} : (sel == 1) ? {20'd0, out1} : {24'd0, out2};
    endfunction

    task automatic drive(input int sel, input logic s, input int v);
        case (sel)
            0: begin st0 = s; bin0 = 16'(v); end
            1: begin st1 = s; bin1 = 8'(v); end
            default: begin st2 = s; bin2 = 8'(v); end
        endcase
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One conversion; poke raises start mid-shift and in the finishing cycle.
    task automatic run_conv(input int sel, input int val, input bit poke);
        int w = (sel == 0) ? 16 : 8;
        int nd = (sel == 0) ? 5 : (sel == 1) ? 3 : 2;
        int mval = val & ((1 << w) - 1);
        int cycles = 0;
        logic [31:0] exp = exp_bcd(mval, nd);
        logic [31:0] held;
        @(negedge clk);
        drive(sel, 1'b1, mval);
        @(negedge clk);
        drive(sel, 1'b0, ~mval);
        while (cycles < 100) begin
            @(negedge clk);
            cycles++;
            if (get_done(sel)) break;
            drive(sel, poke && (cycles == 2 || cycles == w), (cycles * 37) ^ mval);
        end
        drive(sel, 1'b0, 0);
        // R3 latency, R4/R5 value, R2 capture
        check(cycles == w + 1, "R3 latency", 32'(cycles), 32'(w + 1));
        if (mval >= ((nd == 2) ? 100 : (nd == 3) ? 1000 : 100000))
            check(get_out(sel) == exp, "R5 wrap", get_out(sel), exp);
        else
            check(get_out(sel) == exp, "R4 value R2", get_out(sel), exp);
        held = get_out(sel);
        @(negedge clk);
        check(get_done(sel) == 1'b0, "R3 one cycle", 32'(get_done(sel)), 0);
        if (poke) begin
            // R6: no extra done, R7: output held
            for (int k = 0; k < w + 3; k++) begin
                @(negedge clk);
                check(get_done(sel) == 1'b0 && get_out(sel) == held, "R6 R7 hold",
                      get_out(sel), held);
            end
        end
    endtask

    initial begin
        #(4ns * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(out0 == '0 && dn0 == 1'b0, "R1 reset", {12'd0, out0}, 0);
        check(out1 == '0 && out2 == '0 && dn1 == 1'b0 && dn2 == 1'b0, "R1 reset", {20'd0, out1}, 0);
        rst_n = 1'b1;
        // R4 R8: full sweep of the 3-digit instance
        for (int v = 0; v < 256; v++) run_conv(1, v, 1'b0);
        // R5: full sweep of the 2-digit instance
        for (int v = 0; v < 256; v++) run_conv(2, v, 1'b0);
        // Default instance: directed corners
        run_conv(0, 0, 1'b0);
        run_conv(0, 65535, 1'b0);
        run_conv(0, 9999, 1'b0);
        run_conv(0, 10000, 1'b0);
        run_conv(0, 59999, 1'b0);
        run_conv(0, 12345, 1'b1);
        // R9: large value then zero must give zero
        run_conv(0, 49999, 1'b0);
        run_conv(0, 0, 1'b0);
        run_conv(1, 255, 1'b1);
        run_conv(1, 0, 1'b0);
        for (int v = 1; v < 65536; v = v * 3 + 1) run_conv(0, v, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule